// File: doc/BRIEF.md
# Alarm and Clock-Output Controller

This block compares the running calendar against a set of alarm fields and reports a hit on one shared open-drain interrupt pin and on an alarm status flag. Each alarm field has its own enable bit, and only enabled fields take part in the comparison. A mode input picks one of two behaviours. In latched mode the pin stays low until software clears the flag. In pulsed mode every match produces a fixed-length low pulse on the pin, so a match can recur every minute or as rarely as once a year.

The same pin can instead carry a divided clock. A non-zero frequency-select code routes one of fifteen taps of an external divider chain to the pin, and while this is on the alarm logic is fully disabled. A battery-keep input decides whether the alarm and the clock output stay active while the system runs from its backup supply. The divider chain and the register access path sit outside this block. They supply the tap vector, a once-per-second strobe and a millisecond strobe.

Top module: `alarm_clkout_ctrl`

## Requirements
- R1: Alarm fields are packed 8 bits each in `alm_cfg_i`, and calendar fields 7 bits each in `cur_time_i`, in the order index 0 second, 1 minute, 2 hour, 3 date, 4 month, 5 day of week. Bit 7 of an alarm field enables it and bits 6:0 hold the compare value. A match needs every enabled field equal to its calendar field and at least one field enabled. Disabled fields are ignored.
- R2: The match is evaluated only in a cycle with `sec_tick_i` high. A matching calendar with no tick sets nothing, and each tick yields at most one alarm event.
- R3: In latched mode (`im_i`=0), an event sets `alm_o` at the next clock edge. `irq_oe_no` goes to 0 (pin pulled low) one cycle after `alm_o` rises and stays there while `alm_o` is set.
- R4: In pulsed mode (`im_i`=1), an event sets `alm_o` and pulls `irq_oe_no` low, starting one cycle after the event edge. The pin stays low for exactly PULSE_MS rising `ms_tick_i` strobes and is released one cycle after the last one. A later match starts a new pulse. `alm_o` stays set after the pulse ends.
- R5: `alm_clr_i` clears `alm_o` at the next edge. If an event occurs in the same cycle, the event wins.
- R6: With `arst_i`=1, a status read (`stat_rd_i`) clears `alm_o`. With `arst_i`=0, a read leaves it set.
- R7: With `fo_sel_i` non-zero, no alarm event occurs and `alm_o` cannot become set.
- R8: A code k from 1 to 15 drives `irq_oe_no` with `div_taps_i[k-1]` one cycle later. Tap 0 is the fastest (32 kHz) and tap 14 the slowest (1/32 Hz). Code 0 turns clock output off.
- R9: With `on_battery_i`=1 and `bat_keep_i`=0, no alarm event occurs and the pin is released (`irq_oe_no`=1) from the next cycle, including in clock-output mode. With `bat_keep_i`=1 both functions keep working on battery.
- R10: After reset `alm_o`=0 and `irq_oe_no`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sec_tick_i | input | 1 | One-cycle strobe per calendar second |
| ms_tick_i | input | 1 | One-cycle strobe per millisecond |
| cur_time_i | input | NF*7 | Packed calendar fields |
| alm_cfg_i | input | NF*8 | Packed alarm fields, bit 7 enable |
| div_taps_i | input | NUM_TAPS | Divider chain taps, index 0 fastest |
| im_i | input | 1 | 0 latched, 1 pulsed |
| arst_i | input | 1 | Auto-clear of flag on status read |
| fo_sel_i | input | SEL_W | Clock output select, 0 off |
| bat_keep_i | input | 1 | Keep functions active on battery |
| on_battery_i | input | 1 | System runs from backup supply |
| alm_clr_i | input | 1 | Software clear of the alarm flag |
| stat_rd_i | input | 1 | Status register read strobe |
| alm_o | output | 1 | Alarm status flag |
| irq_oe_no | output | 1 | Open-drain enable, 0 pulls pin low |

## Verification
The assertions check on every cycle that the pulse counter never exceeds its length and steps down by one per millisecond strobe. They also check that an event always sets the flag, that the flag cannot rise without a second tick, while clock output is on, or while the battery gate is closed, that an auto-clear read empties it, and that the gated pin is released. Only the directed scenarios can show the field-level match (which fields are ignored, and that no enabled field means no match), the exact pulse length counted in strobes, the priority of set over clear, and which tap each select code routes to the pin.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int FW = 7;  // calendar field width
  localparam int CW = 8;  // alarm field width, msb = enable

  typedef enum logic [2:0] {
    F_SEC  = 3'd0,
    F_MIN  = 3'd1,
    F_HOUR = 3'd2,
    F_DATE = 3'd3,
    F_MON  = 3'd4,
    F_DOW  = 3'd5
  } field_e;

  typedef enum logic {
    MODE_LATCH = 1'b0,
    MODE_PULSE = 1'b1
  } alm_mode_e;
endpackage

// File: rtl/alm_match.sv
module alm_match
  import alm_pkg::*;
#(
  parameter int NF = 6
) (
  input  logic [NF*FW-1:0] cur_time_i,
  input  logic [NF*CW-1:0] alm_cfg_i,
  output logic             any_en_o,
  output logic             match_o
);
  logic [NF-1:0] fld_en;
  logic [NF-1:0] fld_ok;

  for (genvar f = 0; f < NF; f++) begin : g_fld
    assign fld_en[f] = alm_cfg_i[f*CW + CW-1];
    assign fld_ok[f] = !fld_en[f] ||
                       (alm_cfg_i[f*CW +: FW] == cur_time_i[f*FW +: FW]);
  end

  assign any_en_o = |fld_en;
  assign match_o  = any_en_o && (&fld_ok);
endmodule

// File: rtl/alm_pulse_timer.sv
module alm_pulse_timer #(
  parameter int PULSE_MS = 250,
  localparam int CNT_W = $clog2(PULSE_MS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic load_i,
  input  logic ms_tick_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!run_i)                  cnt_q <= '0;
    else if (load_i)                  cnt_q <= CNT_W'(PULSE_MS);
    else if (ms_tick_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != 0);

  p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(PULSE_MS));

  p_cnt_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && ms_tick_i && cnt_q != 0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/fout_sel.sv
module fout_sel #(
  parameter int NUM_TAPS = 15,
  parameter int SEL_W    = $clog2(NUM_TAPS + 1)
) (
  input  logic [NUM_TAPS-1:0] taps_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic                on_o,
  output logic                tap_o
);
  always_comb begin
    tap_o = 1'b1;
    for (int k = 1; k <= NUM_TAPS; k++) begin
      if (sel_i == SEL_W'(k)) tap_o = taps_i[k-1];
    end
  end

  assign on_o = (sel_i != '0);
endmodule

// File: rtl/alarm_clkout_ctrl.sv
module alarm_clkout_ctrl
  import alm_pkg::*;
#(
  parameter int NF       = 6,
  parameter int PULSE_MS = 250,
  parameter int NUM_TAPS = 15,
  parameter int SEL_W    = $clog2(NUM_TAPS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sec_tick_i,
  input  logic                ms_tick_i,
  input  logic [NF*FW-1:0]    cur_time_i,
  input  logic [NF*CW-1:0]    alm_cfg_i,
  input  logic [NUM_TAPS-1:0] div_taps_i,
  input  logic                im_i,
  input  logic                arst_i,
  input  logic [SEL_W-1:0]    fo_sel_i,
  input  logic                bat_keep_i,
  input  logic                on_battery_i,
  input  logic                alm_clr_i,
  input  logic                stat_rd_i,
  output logic                alm_o,
  output logic                irq_oe_no
);
  logic any_en, match;
  logic fo_req, fo_tap;
  logic active, fo_on, armed, evt;
  logic pulse_busy, pull, oe_n_d;
  logic alm_q, oe_n_q;
  alm_mode_e mode;

  assign mode = alm_mode_e'(im_i);

  alm_match #(.NF(NF)) u_match (
    .cur_time_i (cur_time_i),
    .alm_cfg_i  (alm_cfg_i),
    .any_en_o   (any_en),
    .match_o    (match)
  );

  fout_sel #(.NUM_TAPS(NUM_TAPS), .SEL_W(SEL_W)) u_fout (
    .taps_i (div_taps_i),
    .sel_i  (fo_sel_i),
    .on_o   (fo_req),
    .tap_o  (fo_tap)
  );

  // battery gate, then clock output overrides alarm
  assign active = !on_battery_i || bat_keep_i;
  assign fo_on  = fo_req && active;
  assign armed  = !fo_req && active && any_en;
  assign evt    = armed && sec_tick_i && match;

  alm_pulse_timer #(.PULSE_MS(PULSE_MS)) u_pulse (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (armed && mode == MODE_PULSE),
    .load_i    (evt),
    .ms_tick_i (ms_tick_i),
    .busy_o    (pulse_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        alm_q <= 1'b0;
    else if (evt)                       alm_q <= 1'b1;
    else if (alm_clr_i)                 alm_q <= 1'b0;
    else if (stat_rd_i && arst_i)       alm_q <= 1'b0;
  end

  assign pull   = armed && ((mode == MODE_PULSE) ? pulse_busy : alm_q);
  assign oe_n_d = fo_on ? fo_tap : !pull;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_n_q <= 1'b1;
    else         oe_n_q <= oe_n_d;
  end

  assign alm_o     = alm_q;
  assign irq_oe_no = oe_n_q;

  p_evt_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> alm_o);

  p_tick_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_tick_i && !alm_o) |=> !alm_o);

  p_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alm_clr_i && !evt) |=> !alm_o);

  p_arst_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && arst_i && !evt) |=> !alm_o);

  p_fo_no_alarm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fo_sel_i != '0 && !alm_o) |=> !alm_o);

  p_bat_no_alarm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_battery_i && !bat_keep_i && !alm_o) |=> !alm_o);

  p_bat_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_battery_i && !bat_keep_i) |=> irq_oe_no);
endmodule

// File: tb/tb_alarm_clkout_ctrl.sv
module tb_alarm_clkout_ctrl;
  localparam int NF = 6;
  localparam int PULSE_MS = 250;
  localparam int NUM_TAPS = 15;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sec_tick = 0, ms_tick = 0, im = 0, arst = 0;
  logic bat_keep = 0, on_bat = 0, alm_clr = 0, stat_rd = 0;
  logic [3:0] fo_sel = '0;
  logic [NUM_TAPS-1:0] taps = '0;
  logic [6:0] cur [NF];
  logic [7:0] cfg [NF];
  logic [NF*7-1:0] cur_p;
  logic [NF*8-1:0] cfg_p;
  logic alm, oe_n;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  always_comb begin
    for (int f = 0; f < NF; f++) begin
      cur_p[f*7 +: 7] = cur[f];
      cfg_p[f*8 +: 8] = cfg[f];
    end
  end

  alarm_clkout_ctrl #(.NF(NF), .PULSE_MS(PULSE_MS), .NUM_TAPS(NUM_TAPS)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sec_tick_i(sec_tick), .ms_tick_i(ms_tick),
    .cur_time_i(cur_p), .alm_cfg_i(cfg_p), .div_taps_i(taps), .im_i(im),
    .arst_i(arst), .fo_sel_i(fo_sel), .bat_keep_i(bat_keep), .on_battery_i(on_bat),
    .alm_clr_i(alm_clr), .stat_rd_i(stat_rd), .alm_o(alm), .irq_oe_no(oe_n)
  );

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sec_pulse();
    sec_tick = 1'b1;
    step();
    sec_tick = 1'b0;
  endtask

  task automatic tidy();
    for (int f = 0; f < NF; f++) begin
      cfg[f] = 8'h00;
      cur[f] = 7'h00;
    end
    fo_sel = '0; im = 0; arst = 0; on_bat = 0; bat_keep = 0;
    alm_clr = 1'b1;
    step();
    alm_clr = 1'b0;
    step();
  endtask

  task automatic t_reset();
    chk("R10 alm", alm, 1'b0);
    chk("R10 pin", oe_n, 1'b1);
  endtask

  task automatic t_latched();
    tidy();
    cfg[0] = 8'h80 | 8'h30;
    cur[0] = 7'h30;
    step(); step(); step();
    chk("R2 no tick no alarm", alm, 1'b0);
    sec_pulse();
    chk("R3 alm set", alm, 1'b1);
    chk("R3 pin not yet", oe_n, 1'b1);
    step();
    chk("R3 pin low", oe_n, 1'b0);
    step(); step();
    chk("R3 pin held", oe_n, 1'b0);
  endtask

  task automatic t_fields();
    tidy();
    cfg[0] = 8'h80 | 8'h10;
    cfg[2] = 8'h80 | 8'h08;
    cfg[1] = 8'h22;
    cur[0] = 7'h10; cur[2] = 7'h09; cur[1] = 7'h55;
    sec_pulse();
    chk("R1 enabled field mismatch", alm, 1'b0);
    cur[2] = 7'h08;
    sec_pulse();
    chk("R1 disabled field ignored", alm, 1'b1);
    tidy();
    cfg[3] = 8'h05; cur[3] = 7'h05;
    sec_pulse();
    chk("R1 no enabled field", alm, 1'b0);
  endtask

  task automatic t_clear();
    tidy();
    cfg[0] = 8'h80 | 8'h01; cur[0] = 7'h01;
    sec_pulse();
    chk("R5 pre set", alm, 1'b1);
    cur[0] = 7'h02;
    alm_clr = 1'b1;
    step();
    alm_clr = 1'b0;
    chk("R5 cleared", alm, 1'b0);
    step();
    chk("R5 pin released", oe_n, 1'b1);
    cur[0] = 7'h01;
    alm_clr = 1'b1;
    sec_pulse();
    alm_clr = 1'b0;
    chk("R5 set wins", alm, 1'b1);
  endtask

  task automatic t_arst();
    tidy();
    cfg[1] = 8'h80 | 8'h07; cur[1] = 7'h07;
    sec_pulse();
    cur[1] = 7'h08;
    stat_rd = 1'b1;
    step();
    stat_rd = 1'b0;
    chk("R6 read without arst", alm, 1'b1);
    arst = 1'b1;
    stat_rd = 1'b1;
    step();
    stat_rd = 1'b0;
    chk("R6 read with arst", alm, 1'b0);
  endtask

  task automatic t_pulsed();
    tidy();
    im = 1'b1;
    cfg[0] = 8'h80 | 8'h15; cur[0] = 7'h15;
    sec_pulse();
    cur[0] = 7'h16;
    chk("R4 alm set", alm, 1'b1);
    step();
    chk("R4 pin low", oe_n, 1'b0);
    for (int k = 1; k <= PULSE_MS; k++) begin
      ms_tick = 1'b1;
      step();
      ms_tick = 1'b0;
      step();
      if (k == PULSE_MS - 1) chk("R4 pin low before last tick", oe_n, 1'b0);
      if (k == PULSE_MS)     chk("R4 pin released after last tick", oe_n, 1'b1);
    end
    chk("R4 alm stays", alm, 1'b1);
    cur[0] = 7'h15;
    sec_pulse();
    step();
    chk("R4 repeat pulse", oe_n, 1'b0);
  endtask

  task automatic t_fout();
    tidy();
    cfg[0] = 8'h80 | 8'h20; cur[0] = 7'h20;
    fo_sel = 4'd3;
    taps = '0;
    sec_pulse();
    chk("R7 alarm blocked", alm, 1'b0);
    chk("R8 code 3 tap low", oe_n, 1'b0);
    taps[2] = 1'b1;
    step();
    chk("R8 code 3 tap high", oe_n, 1'b1);
    fo_sel = 4'd15;
    taps = '0;
    taps[14] = 1'b1;
    step();
    chk("R8 code 15 slowest tap", oe_n, 1'b1);
    taps[14] = 1'b0;
    step();
    chk("R8 code 15 follows", oe_n, 1'b0);
    fo_sel = 4'd1;
    taps = '1;
    taps[0] = 1'b0;
    step();
    chk("R8 code 1 fastest tap", oe_n, 1'b0);
    fo_sel = 4'd0;
    taps = '0;
    cfg[0] = 8'h00;
    step();
    chk("R8 code 0 off", oe_n, 1'b1);
  endtask

  task automatic t_battery();
    tidy();
    cfg[4] = 8'h80 | 8'h0c; cur[4] = 7'h0c;
    on_bat = 1'b1;
    sec_pulse();
    chk("R9 alarm gated", alm, 1'b0);
    fo_sel = 4'd2;
    taps = '0;
    step();
    chk("R9 clock out gated", oe_n, 1'b1);
    bat_keep = 1'b1;
    step();
    chk("R9 clock out kept", oe_n, 1'b0);
    fo_sel = 4'd0;
    sec_pulse();
    chk("R9 alarm kept", alm, 1'b1);
    step();
    chk("R9 pin low kept", oe_n, 1'b0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    for (int f = 0; f < NF; f++) begin
      cur[f] = 7'h00;
      cfg[f] = 8'h00;
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_latched();
    t_fields();
    t_clear();
    t_arst();
    t_pulsed();
    t_fout();
    t_battery();
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule